// File: doc/BRIEF.md
# Folded Symmetric Eight-Tap FIR Filter

This block filters a stream of signed 8-bit samples with a fixed, symmetric set of eight integer weights and returns signed 16-bit results. Samples come in on a valid-only interface with no ready signal. A new sample may arrive on every clock cycle. Each accepted sample produces exactly one result. Results leave in arrival order and are marked by an output strobe.

The weights mirror around the centre, so the weight at tap k equals the weight at tap 7-k. The block uses this to add each mirrored pair of stored samples before it multiplies them. This needs four multipliers instead of eight.

Processing runs in four register stages:
- the sample history,
- the pair products,
- the partial sums,
- the final total.

The stored history moves only when a sample is accepted.

Top module: `fir_sym_top`

## Requirements
- R1: When reset is high at a rising edge, every stored sample becomes zero and `dout_vld` goes low. Results computed after reset use zero in place of samples that were never accepted.
- R2: A sample of 1 followed by zeros, sent directly after reset, gives the results 8, 21, 45, 54, 54, 45, 21, 8 and then 0.
- R3: Each result equals the sum over k = 0..7 of w[k] times the sample accepted k samples earlier, where w = {8, 21, 45, 54, 54, 45, 21, 8} and k = 0 is the newest sample.
- R4: Each sample accepted at a rising edge produces exactly one result, in arrival order. That result, with `dout_vld` high, appears after the third rising edge that follows the accepting edge.
- R5: When `din_vld` is high on consecutive cycles, every one of those samples is accepted and filtered.
- R6: A cycle with `din_vld` low leaves the stored history unchanged. Results with idle gaps between samples equal the results with no gaps.
- R7: Full-scale input that alternates between +127 and -128 gives exact results.
- R8: `dout` is a 16-bit two's-complement value that holds the low 16 bits of the exact sum. A steady input of -128 settles at -32768.
- R9: A reset applied while results are still in the pipeline discards them: no `dout_vld` pulse appears for samples accepted before that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Signed input sample |
| din_vld | input | 1 | Input strobe; the sample is accepted on this edge |
| dout | output | 16 | Signed filtered result |
| dout_vld | output | 1 | High for one cycle for each result |

## Verification
The hardest situation to create from the ports is a reset that arrives while results are still moving through the product and sum stages. At that point the history is clear but partial sums are still in flight. The bench sends a short burst and raises reset on the very next cycle. It then watches for any stray strobe, and afterwards sends an impulse to confirm that no old sample leaks into the new results.

Gapped input is the second such case. The bench inserts idle cycles of varying length between ramp samples. Its model ignores those cycles, so any zero shifted into the history during an idle cycle shows up as a wrong value.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

    // Number of register stages from input capture to result.
    localparam int FIR_PIPE = 4;

    // Fixed symmetric weight set, indexed from the newest sample.
    function automatic int coef_at(input int k);
        case (k)
            0, 7:    return 8;
            1, 6:    return 21;
            2, 5:    return 45;
            3, 4:    return 54;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
    parameter int SMP_W = 8,
    parameter int NTAP  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SMP_W-1:0]        in_smp,
    input  logic                    in_vld,
    output logic [NTAP*SMP_W-1:0]   taps
);

    typedef struct packed {
        logic [NTAP-1:0][SMP_W-1:0] hist;
    } line_t;

    line_t line_d, line_q;

    // History moves only on an accepted sample; slot 0 is the newest.
    always_comb begin
        line_d = line_q;
        if (in_vld) begin
            line_d.hist[0] = in_smp;
            for (int k = 1; k < NTAP; k++) begin
                line_d.hist[k] = line_q.hist[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign taps = line_q.hist;

endmodule

// File: rtl/fir_pair_mac.sv
module fir_pair_mac #(
    parameter int SMP_W = 8,
    parameter int CF_W  = 8,
    parameter int COEF  = 8,
    localparam int PRE_W  = SMP_W + 1,
    localparam int PROD_W = PRE_W + CF_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SMP_W-1:0]     smp_a,
    input  logic [SMP_W-1:0]     smp_b,
    output logic [PROD_W-1:0]    prod
);

    typedef struct packed {
        logic [PROD_W-1:0] prod;
    } mac_t;

    mac_t mac_d, mac_q;

    logic signed [PRE_W-1:0]  pre_sum;
    logic signed [PROD_W-1:0] pre_x;
    logic signed [PROD_W-1:0] cf_x;

    // Mirrored samples are summed at one extra bit, then scaled once.
    always_comb begin
        pre_sum    = $signed({smp_a[SMP_W-1], smp_a}) + $signed({smp_b[SMP_W-1], smp_b});
        pre_x      = PROD_W'(pre_sum);
        cf_x       = PROD_W'(COEF);
        mac_d.prod = pre_x * cf_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign prod = mac_q.prod;

endmodule

// File: rtl/fir_sum_tree.sv
module fir_sum_tree #(
    parameter int NPAIR  = 4,
    parameter int PROD_W = 17,
    parameter int RES_W  = 16,
    localparam int NHALF  = (NPAIR + 1) / 2,
    localparam int PART_W = PROD_W + 1,
    localparam int TOT_W  = PART_W + $clog2(NHALF) + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPAIR*PROD_W-1:0]   prods,
    output logic [RES_W-1:0]          total
);

    typedef struct packed {
        logic [NHALF-1:0][PART_W-1:0] part;
        logic [RES_W-1:0]             tot;
    } tree_t;

    tree_t tree_d, tree_q;

    logic signed [PART_W-1:0] pa;
    logic signed [PART_W-1:0] pb;
    logic signed [TOT_W-1:0]  acc;

    // Level one adds neighbouring products; level two adds the partials
    // and keeps the low RES_W bits (two's-complement wrap).
    always_comb begin
        tree_d = tree_q;
        pa     = '0;
        pb     = '0;
        for (int h = 0; h < NHALF; h++) begin
            pa = PART_W'($signed(prods[(2*h)*PROD_W +: PROD_W]));
            if (2*h + 1 < NPAIR) begin
                pb = PART_W'($signed(prods[(2*h+1)*PROD_W +: PROD_W]));
            end else begin
                pb = '0;
            end
            tree_d.part[h] = pa + pb;
        end
        acc = '0;
        for (int h = 0; h < NHALF; h++) begin
            acc = acc + TOT_W'($signed(tree_q.part[h]));
        end
        tree_d.tot = acc[RES_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tree_q <= '0;
        end else begin
            tree_q <= tree_d;
        end
    end

    assign total = tree_q.tot;

endmodule

// File: rtl/fir_sym_top.sv
module fir_sym_top #(
    parameter int SMP_W = 8,
    parameter int RES_W = 16,
    parameter int NTAP  = 8,
    parameter int CF_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  din,
    input  logic              din_vld,
    output logic [RES_W-1:0]  dout,
    output logic              dout_vld
);

    localparam int NPAIR  = NTAP / 2;
    localparam int PROD_W = SMP_W + 1 + CF_W;
    localparam int PIPE   = fir_sym_pkg::FIR_PIPE;

    logic [NTAP*SMP_W-1:0]  tap_flat;
    logic [NPAIR*PROD_W-1:0] prod_flat;

    typedef struct packed {
        logic [PIPE-1:0] vld;
    } flag_t;

    flag_t flag_d, flag_q;

    fir_tap_line #(
        .SMP_W (SMP_W),
        .NTAP  (NTAP)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .in_smp (din),
        .in_vld (din_vld),
        .taps   (tap_flat)
    );

    // One pre-add multiplier per mirrored tap pair.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        fir_pair_mac #(
            .SMP_W (SMP_W),
            .CF_W  (CF_W),
            .COEF  (fir_sym_pkg::coef_at(p))
        ) u_mac (
            .clk   (clk),
            .rst   (rst),
            .smp_a (tap_flat[p*SMP_W +: SMP_W]),
            .smp_b (tap_flat[(NTAP-1-p)*SMP_W +: SMP_W]),
            .prod  (prod_flat[p*PROD_W +: PROD_W])
        );
    end

    fir_sum_tree #(
        .NPAIR  (NPAIR),
        .PROD_W (PROD_W),
        .RES_W  (RES_W)
    ) u_tree (
        .clk   (clk),
        .rst   (rst),
        .prods (prod_flat),
        .total (dout)
    );

    // Strobe follows the data through the same number of registers.
    always_comb begin
        flag_d.vld = {flag_q.vld[PIPE-2:0], din_vld};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign dout_vld = flag_q.vld[PIPE-1];

endmodule

// File: rtl/fir_sym_chk.sv
module fir_sym_chk #(
    parameter int SMP_W = 8,
    parameter int NTAP  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SMP_W-1:0]       din,
    input  logic                   din_vld,
    input  logic                   dout_vld,
    input  logic [NTAP*SMP_W-1:0]  hist
);

    p_vld_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dout_vld);

    p_one_result_r4: assert property (@(posedge clk) disable iff (rst)
        din_vld |-> ##4 dout_vld);

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        !din_vld |-> ##4 !dout_vld);

    p_shift_in_r5: assert property (@(posedge clk) disable iff (rst)
        din_vld |=> (hist[SMP_W-1:0] == $past(din)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> $stable(hist));

endmodule

bind fir_sym_top fir_sym_chk #(
    .SMP_W (SMP_W),
    .NTAP  (NTAP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .din_vld  (din_vld),
    .dout_vld (dout_vld),
    .hist     (tap_flat)
);

// File: tb/tb_fir_sym_top.sv
`timescale 1ns / 1ps
module tb_fir_sym_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  din = '0;
    logic        din_vld = 1'b0;
    logic [15:0] dout;
    logic        dout_vld;

    fir_sym_top dut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .din_vld  (din_vld),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    val;
        int    due;
        string req;
    } exp_t;

    exp_t  expq[$];
    int    got[$];
    int    n_chk = 0;
    int    n_err = 0;
    int    n_unexp = 0;
    int    cyc = 0;
    int    wt[8] = '{8, 21, 45, 54, 54, 45, 21, 8};
    int    mh[8];
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor: value, order and latency against the model.
    always @(negedge clk) begin
        if (dout_vld) begin
            got.push_back(int'($signed(dout)));
            if (expq.size() == 0) begin
                n_unexp++;
                check(1'b0, "R9 unexpected result", int'($signed(dout)), 0);
            end else begin
                check(int'($signed(dout)) == expq[0].val, expq[0].req,
                      int'($signed(dout)), expq[0].val);
                check(cyc == expq[0].due, "R4 latency", cyc, expq[0].due);
                void'(expq.pop_front());
            end
        end else if (expq.size() != 0 && expq[0].due == cyc) begin
            check(1'b0, "R4 missing result", 0, 1);
            void'(expq.pop_front());
        end
    end

    function automatic void model_clear();
        for (int k = 0; k < 8; k++) mh[k] = 0;
    endfunction

    task automatic send(input int s, input string req);
        int sum;
        logic [15:0] w;
        @(negedge clk);
        din     = 8'(s);
        din_vld = 1'b1;
        for (int k = 7; k > 0; k--) mh[k] = mh[k-1];
        mh[0] = s;
        sum = 0;
        for (int k = 0; k < 8; k++) sum += wt[k] * mh[k];
        w = sum[15:0];
        expq.push_back('{val: int'($signed(w)), due: cyc + 4, req: req});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            din_vld = 1'b0;
        end
    endtask

    task automatic drain(input string req);
        idle(1);
        for (int i = 0; i < 20 && expq.size() != 0; i++) idle(1);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        din_vld = 1'b0;
        rst     = 1'b1;
        @(posedge clk);
        #1;
        expq.delete();
        model_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(dout_vld == 1'b0, "R1 vld low after reset", int'(dout_vld), 0);
    endtask

    task automatic t_impulse();
        int ref_v[10] = '{8, 21, 45, 54, 54, 45, 21, 8, 0, 0};
        do_reset();
        got.delete();
        send(1, "R3 impulse");
        for (int i = 0; i < 9; i++) send(0, "R3 impulse");
        drain("R4 impulse count");
        check(got.size() == 10, "R2 count", got.size(), 10);
        for (int i = 0; i < 10 && i < got.size(); i++)
            check(got[i] == ref_v[i], "R2 impulse tap", got[i], ref_v[i]);
    endtask

    task automatic t_step();
        do_reset();
        for (int i = 0; i < 20; i++) send(50, "R5 back-to-back step");
        drain("R5 step count");
    endtask

    task automatic t_gapped();
        do_reset();
        for (int i = 0; i < 20; i++) begin
            send(i * 5, "R6 gapped ramp");
            idle(i % 4);
        end
        drain("R6 ramp count");
    endtask

    task automatic t_fullscale();
        do_reset();
        for (int i = 0; i < 16; i++) send((i % 2 == 0) ? 127 : -128, "R7 full scale");
        drain("R7 count");
    endtask

    task automatic t_negmax();
        do_reset();
        got.delete();
        for (int i = 0; i < 12; i++) send(-128, "R8 negative step");
        drain("R8 count");
        check(got.size() > 0 && got[got.size()-1] == -32768, "R8 settle",
              (got.size() > 0) ? got[got.size()-1] : 0, -32768);
    endtask

    task automatic t_midreset();
        do_reset();
        for (int i = 0; i < 5; i++) send(100 - i * 30, "R9 pre-reset");
        n_unexp = 0;
        do_reset();
        idle(8);
        check(n_unexp == 0, "R9 stale results", n_unexp, 0);
        got.delete();
        send(1, "R1 post-reset impulse");
        drain("R1 count");
        check(got.size() > 0 && got[0] == 8, "R1 history cleared",
              (got.size() > 0) ? got[0] : 0, 8);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        t_reset();
        t_impulse();
        t_step();
        t_gapped();
        t_fullscale();
        t_negmax();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule